// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog that escalates on each timer interval expiration that software fails to answer. An expiration is the rising edge of one chosen bit of an external free-running time-base counter. Two status flags record how far the escalation has gone: an arm flag and an alarm flag. The first unanswered expiration sets the arm flag. The second sets the alarm flag, which can raise a maskable interrupt. The third requests a reset of the severity that software has programmed.

Software keeps the block quiet by clearing the arm flag more often than one interval. It can also clear the alarm flag from its interrupt handler. When the block requests a reset, it records the kind of reset it requested and clears the severity field. This disarms further resets until software programs a new severity. The block does not generate the reset itself. It only issues a one-clock request on the core, chip or system output.

Top module: `wdt_escalator`

Register map (`regSel`): 0 selects the control register and 1 selects the status register.
- Control register: bits [1:0] hold the reset severity, bits [3:2] hold the tap select and bit 4 holds the interrupt enable.
- Status register: bit 0 is the arm flag and bit 1 is the alarm flag. Bits [3:2] hold the last reset kind and are read-only.

## Requirements
- R1: An expiration while the arm flag (status bit 0) is 0 sets the arm flag to 1 and changes nothing else, whatever the alarm flag holds.
- R2: An expiration while the arm flag is 1 and the alarm flag (status bit 1) is 0 sets the alarm flag to 1.
- R3: `wdIrq` is 1 exactly when the alarm flag, the interrupt enable (control bit 4) and `critIntEn` are all 1.
- R4: An expiration while both flags are 1 causes a pulse of exactly one clock, in the cycle after the processing edge. The severity field (control bits [1:0]) selects the output: 01 pulses `coreRstReq`, 10 pulses `chipRstReq`, 11 pulses `sysRstReq`, and 00 pulses no output.
- R5: When a reset pulse is issued, the severity value is copied into the last-reset field (status bits [3:2]) and the severity field is cleared to 00.
- R6: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 leaves the flag unchanged.
- R7: While the severity field is nonzero, writes cannot change it. The other control fields stay writable.
- R8: An expiration is a 0-to-1 transition of time-base bit `TAP_BASE + k*TAP_STEP`, where k is the tap select (control bits [3:2]). With the defaults, this is bit 4, 6, 8 or 10. Edges on the other taps are ignored.
- R9: If a software clear and an expiration's set reach the same flag in the same cycle, the flag ends at 1.
- R10: Reset (`rstN` low) clears every control and status field, and all requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timeBase | input | TB_W | Free-running time-base count |
| critIntEn | input | 1 | Global critical-interrupt enable |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 1 | Write target: 0 control, 1 status |
| wrData | input | DATA_W | Write data |
| rdSel | input | 1 | Read source: 0 control, 1 status |
| rdData | output | DATA_W | Read data (combinational) |
| wdIrq | output | 1 | Watchdog interrupt |
| coreRstReq | output | 1 | One-clock core reset request |
| chipRstReq | output | 1 | One-clock chip reset request |
| sysRstReq | output | 1 | One-clock system reset request |

## Verification
A software write-1-to-clear of a flag and an expiration that sets the same flag can fall in the same clock. The bench provokes this by raising the tap bit and issuing the status write in the same cycle. It does so once on the arm flag and once on the alarm flag, and checks the read-back flag against the rule that the set wins. A severity write while the severity is locked is also paired with the reset that later releases the lock. The bench checks that the field is frozen, and that it is cleared and recorded on the reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Strobes from the control decoder into the register datapath.
  typedef struct packed {
    logic setArm;
    logic setAlarm;
    logic fireReset;
  } wdtStrobe_t;

  typedef enum logic [1:0] {
    SEV_NONE = 2'b00,
    SEV_CORE = 2'b01,
    SEV_CHIP = 2'b10,
    SEV_SYS  = 2'b11
  } sevKind_t;

  localparam int unsigned SEL_W    = 2;
  localparam int unsigned NUM_TAPS = 1 << SEL_W;

endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned TB_W     = 16,
  parameter int unsigned TAP_BASE = 4,
  parameter int unsigned TAP_STEP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TB_W-1:0]  timeBase,
  input  logic [SEL_W-1:0] tapSel,
  input  logic             armFlag,
  input  logic             alarmFlag,
  output wdtStrobe_t       strobe
);

  localparam int unsigned TOP_TAP = TAP_BASE + (NUM_TAPS - 1) * TAP_STEP;

  logic [NUM_TAPS-1:0] tapNow;
  logic [NUM_TAPS-1:0] tapPrev;
  logic [NUM_TAPS-1:0] tapRise;
  logic                expire;

  // Each tap keeps its own history, so changing the selection cannot forge an edge.
  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    assign tapNow[k] = timeBase[TAP_BASE + k * TAP_STEP];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tapPrev <= '0;
    else       tapPrev <= tapNow;
  end

  assign tapRise = tapNow & ~tapPrev;
  assign expire  = tapRise[tapSel];

  // Escalation decode: one stage per expiration.
  always_comb begin
    strobe = '0;
    if (expire) begin
      if (!armFlag)        strobe.setArm    = 1'b1;
      else if (!alarmFlag) strobe.setAlarm  = 1'b1;
      else                 strobe.fireReset = 1'b1;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setArm, strobe.setAlarm, strobe.fireReset})); // R1

  AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fireReset |-> (armFlag && alarmFlag)); // R4

  AST_TAP_RANGE: assert final (TOP_TAP < TB_W); // R8

endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wdtStrobe_t        strobe,
  input  logic              critIntEn,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic [SEL_W-1:0]  tapSel,
  output logic              armFlag,
  output logic              alarmFlag,
  output logic              wdIrq,
  output logic              coreRstReq,
  output logic              chipRstReq,
  output logic              sysRstReq
);

  localparam int unsigned SEV_LSB = 0;
  localparam int unsigned TAP_LSB = SEV_LSB + 2;
  localparam int unsigned IEN_BIT = TAP_LSB + SEL_W;
  localparam int unsigned ARM_BIT = 0;
  localparam int unsigned ALM_BIT = 1;
  localparam int unsigned LRK_LSB = 2;

  logic [1:0] severity;
  logic [1:0] lastKind;
  logic       irqEnable;
  logic       wrCtl;
  logic       wrSts;
  logic       fireNow;
  logic [2:0] reqNext;
  logic [2:0] reqVec;

  assign wrCtl   = wrEn && !regSel;
  assign wrSts   = wrEn && regSel;
  assign fireNow = strobe.fireReset && (severity != SEV_NONE);

  // Control fields; severity is locked while nonzero.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      severity  <= SEV_NONE;
      tapSel    <= '0;
      irqEnable <= 1'b0;
      lastKind  <= SEV_NONE;
    end else begin
      if (wrCtl) begin
        tapSel    <= wrData[TAP_LSB +: SEL_W];
        irqEnable <= wrData[IEN_BIT];
        if (severity == SEV_NONE) severity <= wrData[SEV_LSB +: 2];
      end
      if (fireNow) begin
        lastKind <= severity;
        severity <= SEV_NONE;
      end
    end
  end

  // Escalation flags: the hardware set outranks a software clear.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armFlag   <= 1'b0;
      alarmFlag <= 1'b0;
    end else begin
      if (strobe.setArm)                  armFlag <= 1'b1;
      else if (wrSts && wrData[ARM_BIT])  armFlag <= 1'b0;
      if (strobe.setAlarm)                alarmFlag <= 1'b1;
      else if (wrSts && wrData[ALM_BIT])  alarmFlag <= 1'b0;
    end
  end

  always_comb begin
    reqNext = '0;
    if (fireNow) begin
      unique case (sevKind_t'(severity))
        SEV_CORE: reqNext[0] = 1'b1;
        SEV_CHIP: reqNext[1] = 1'b1;
        SEV_SYS:  reqNext[2] = 1'b1;
        default:  reqNext    = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reqVec <= '0;
    else       reqVec <= reqNext;
  end

  assign coreRstReq = reqVec[0];
  assign chipRstReq = reqVec[1];
  assign sysRstReq  = reqVec[2];
  assign wdIrq      = alarmFlag && irqEnable && critIntEn;

  always_comb begin
    rdData = '0;
    if (rdSel) begin
      rdData[ARM_BIT]       = armFlag;
      rdData[ALM_BIT]       = alarmFlag;
      rdData[LRK_LSB +: 2]  = lastKind;
    end else begin
      rdData[SEV_LSB +: 2]     = severity;
      rdData[TAP_LSB +: SEL_W] = tapSel;
      rdData[IEN_BIT]          = irqEnable;
    end
  end

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({coreRstReq, chipRstReq, sysRstReq})); // R4

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (coreRstReq || chipRstReq || sysRstReq) |=> !(coreRstReq || chipRstReq || sysRstReq)); // R4

  AST_SEV_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (coreRstReq || chipRstReq || sysRstReq) |-> (severity == SEV_NONE)); // R5

  AST_KIND_RECORDED: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |-> (lastKind == SEV_SYS)); // R5

  AST_SEV_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    (severity != SEV_NONE && !strobe.fireReset) |=> $stable(severity)); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setArm |=> armFlag); // R9

endmodule

// File: rtl/wdt_escalator.sv
module wdt_escalator
  import wdt_pkg::*;
#(
  parameter int unsigned TB_W     = 16,
  parameter int unsigned TAP_BASE = 4,
  parameter int unsigned TAP_STEP = 2,
  parameter int unsigned DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TB_W-1:0]   timeBase,
  input  logic              critIntEn,
  input  logic              wrEn,
  input  logic              regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdSel,
  output logic [DATA_W-1:0] rdData,
  output logic              wdIrq,
  output logic              coreRstReq,
  output logic              chipRstReq,
  output logic              sysRstReq
);

  wdtStrobe_t       strobe;
  logic [SEL_W-1:0] tapSel;
  logic             armFlag;
  logic             alarmFlag;

  wdt_ctrl #(
    .TB_W(TB_W), .TAP_BASE(TAP_BASE), .TAP_STEP(TAP_STEP)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .timeBase(timeBase), .tapSel(tapSel),
    .armFlag(armFlag), .alarmFlag(alarmFlag), .strobe(strobe)
  );

  wdt_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .critIntEn(critIntEn),
    .wrEn(wrEn), .regSel(regSel), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .tapSel(tapSel), .armFlag(armFlag),
    .alarmFlag(alarmFlag), .wdIrq(wdIrq), .coreRstReq(coreRstReq),
    .chipRstReq(chipRstReq), .sysRstReq(sysRstReq)
  );

  AST_IRQ_NEEDS_ALARM: assert property (@(posedge clk) disable iff (!rstN)
    wdIrq |-> (alarmFlag && critIntEn)); // R3

  AST_ALARM_AFTER_ARM: assert property (@(posedge clk) disable iff (!rstN)
    $rose(alarmFlag) |-> $past(armFlag)); // R2

endmodule

// File: tb/wdt_escalator_test.sv
`timescale 1ns/1ps
module wdt_escalator_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] timeBase = '0;
  logic        critIntEn = 1'b0;
  logic        wrEn = 1'b0;
  logic        regSel = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdSel = 1'b1;
  logic [7:0]  rdData;
  logic        wdIrq, coreRstReq, chipRstReq, sysRstReq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wdt_escalator uut (
    .clk(clk), .rstN(rstN), .timeBase(timeBase), .critIntEn(critIntEn),
    .wrEn(wrEn), .regSel(regSel), .wrData(wrData), .rdSel(rdSel),
    .rdData(rdData), .wdIrq(wdIrq), .coreRstReq(coreRstReq),
    .chipRstReq(chipRstReq), .sysRstReq(sysRstReq)
  );

  // Vector: {kind[1:0] (0 expire on bit 4, 1 status write), data[7:0], status[3:0], pulses{sys,chip,core}, irq}
  localparam int NV = 8;
  localparam logic [17:0] VEC [NV] = '{
    {2'd0, 8'h00, 4'b0001, 3'b000, 1'b0},  // R1
    {2'd1, 8'h01, 4'b0000, 3'b000, 1'b0},  // R6
    {2'd0, 8'h00, 4'b0001, 3'b000, 1'b0},  // R1
    {2'd0, 8'h00, 4'b0011, 3'b000, 1'b1},  // R2
    {2'd1, 8'h02, 4'b0001, 3'b000, 1'b0},  // R6
    {2'd0, 8'h00, 4'b0011, 3'b000, 1'b1},  // R2
    {2'd0, 8'h00, 4'b0111, 3'b001, 1'b1},  // R4 core
    {2'd0, 8'h00, 4'b0111, 3'b000, 1'b1}   // R4 severity 00
  };

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] d);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic sel, output logic [7:0] d);
    rdSel = sel; #0.5; d = rdData; rdSel = 1'b1;
  endtask

  function automatic logic [7:0] pulses();
    return {5'b0, sysRstReq, chipRstReq, coreRstReq};
  endfunction

  // Raise a tap bit; afterwards the processing edge has passed.
  task automatic raiseTap(input int bitIdx);
    timeBase = 16'(1) << bitIdx;
    @(negedge clk);
  endtask

  task automatic dropTap();
    timeBase = '0;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    // R10: reset state
    readReg(1'b1, rd); check("R10 status at reset", rd, 8'h00);
    readReg(1'b0, rd); check("R10 control at reset", rd, 8'h00);
    check("R10 requests at reset", pulses(), 8'h00);
    check("R10 irq at reset", {7'b0, wdIrq}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    critIntEn = 1'b1;
    writeReg(1'b0, 8'h11);   // irq enable, tap 0, core severity
    for (int i = 0; i < NV; i++) begin
      logic [17:0] v;
      v = VEC[i];
      if (v[17:16] == 2'd0) begin
        raiseTap(4);
        check($sformatf("R4 vector %0d requests", i), pulses(), {5'b0, v[3:1]});
        dropTap();
        check($sformatf("R4 vector %0d pulse gone", i), pulses(), 8'h00);
      end else begin
        writeReg(1'b1, v[15:8]);
      end
      readReg(1'b1, rd);
      check($sformatf("R1 R2 R6 vector %0d status", i), rd, {4'b0, v[7:4]});
      check($sformatf("R3 vector %0d irq", i), {7'b0, wdIrq}, {7'b0, v[0]});
    end
    readReg(1'b0, rd); check("R5 severity cleared after core reset", rd, 8'h10);

    writeReg(1'b1, 8'h03);
    readReg(1'b1, rd); check("R6 flags cleared", rd, 8'h04);

    // R7: lock
    writeReg(1'b0, 8'h12);
    readReg(1'b0, rd); check("R7 severity written when free", rd, 8'h12);
    writeReg(1'b0, 8'h13);
    readReg(1'b0, rd); check("R7 severity locked", rd, 8'h12);
    writeReg(1'b0, 8'h1A);
    readReg(1'b0, rd); check("R7 tap select still writable", rd, 8'h1A);

    // R8: tap 2 selects bit 8
    raiseTap(4); dropTap();
    readReg(1'b1, rd); check("R8 unselected tap ignored", rd, 8'h04);
    raiseTap(8); dropTap();
    readReg(1'b1, rd); check("R8 selected tap expires", rd, 8'h05);

    writeReg(1'b1, 8'h00);
    readReg(1'b1, rd); check("R6 zero write no effect", rd, 8'h05);

    raiseTap(8); dropTap();
    readReg(1'b1, rd); check("R2 alarm set", rd, 8'h07);
    critIntEn = 1'b0; #0.5;
    check("R3 irq masked by global enable", {7'b0, wdIrq}, 8'h00);
    critIntEn = 1'b1; #0.5;
    check("R3 irq asserted", {7'b0, wdIrq}, 8'h01);

    raiseTap(8);
    check("R4 chip request", pulses(), 8'h02);
    dropTap();
    check("R4 chip pulse one clock", pulses(), 8'h00);
    readReg(1'b1, rd); check("R5 chip recorded", rd, 8'h0B);
    readReg(1'b0, rd); check("R5 chip severity cleared", rd, 8'h18);

    writeReg(1'b0, 8'h1F);   // system severity, tap 3 = bit 10
    raiseTap(10);
    check("R4 system request", pulses(), 8'h04);
    dropTap();
    check("R4 system pulse one clock", pulses(), 8'h00);
    readReg(1'b1, rd); check("R5 system recorded", rd, 8'h0F);

    writeReg(1'b0, 8'h0C);
    check("R3 irq masked by enable bit", {7'b0, wdIrq}, 8'h00);

    // R9: set beats clear in the same cycle
    writeReg(1'b1, 8'h03);
    readReg(1'b1, rd); check("R6 flags cleared again", rd, 8'h0C);
    timeBase = 16'h0400; wrEn = 1'b1; regSel = 1'b1; wrData = 8'h01;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    dropTap();
    readReg(1'b1, rd); check("R9 arm set wins over clear", rd, 8'h0D);
    timeBase = 16'h0400; wrEn = 1'b1; regSel = 1'b1; wrData = 8'h02;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    dropTap();
    readReg(1'b1, rd); check("R9 alarm set wins over clear", rd, 8'h0F);

    // R10: reset mid-run
    rstN = 1'b0; #0.5;
    readReg(1'b1, rd); check("R10 status after reset", rd, 8'h00);
    readReg(1'b0, rd); check("R10 control after reset", rd, 8'h00);
    check("R10 irq after reset", {7'b0, wdIrq}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule